// File: doc/BRIEF.md
# Serial Control Port with Automatic Mode Selection

This block is the write side of a device's serial control interface. It watches three pins: a chip-select pin that doubles as the address strap of the two-wire (I2C) target, a serial clock and a serial data line. After reset the device answers on I2C. The first high-to-low transition of the shared pin moves the device into SPI mode for good, and the block then tells the I2C target to stand down. The pins are asynchronous to the system clock, so the block synchronizes them and finds the serial clock edges by oversampling.

A frame starts when chip select goes low. Its first byte is an identity byte that has to equal 0x98. Its second byte loads the register pointer. Each byte after that becomes a one-cycle write request to the shared 8-bit register file. Bit 7 of the pointer is an auto-increment flag and bits 6:0 are the register address. A frame with the wrong identity byte writes nothing. Raising chip select in the middle of a byte throws that byte away.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset `spi_mode` is 0, `i2c_en` is 1 and `reg_we` stays 0.
- R2: A falling edge on `pin_cs_ad0` seen after reset sets `spi_mode` to 1. It stays 1 until the next reset. A pin that is already low when reset is released does not select SPI mode, and neither does a rising edge.
- R3: While `spi_mode` is 1, `i2c_en` is 0. Before SPI mode is selected, no frame produces a write.
- R4: Data on `pin_cdin` is taken at each rising edge of `pin_cclk` while chip select is low. Bytes are assembled most significant bit first.
- R5: The first complete byte of a frame must equal 0x98. If it does not, the rest of the frame causes no write.
- R6: The second complete byte loads the pointer. Bits 6:0 of the pointer are the register address and bit 7 is the auto-increment flag.
- R7: Each complete byte after the pointer byte produces exactly one single-cycle `reg_we` pulse, carrying that byte on `reg_wdata` and the current address on `reg_addr`.
- R8: When the increment flag is 1, the address advances by one after each write and wraps from 0x7F to 0x00. When the flag is 0, every byte writes the same address.
- R9: Raising chip select discards any partial byte and restarts bit counting. Only complete bytes take effect, and a write happens only while a frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_cs_ad0 | input | 1 | Shared pin: I2C address strap, or active-low SPI chip select |
| pin_cclk | input | 1 | Serial control clock |
| pin_cdin | input | 1 | Serial control data |
| spi_mode | output | 1 | 1 once SPI mode has been selected |
| i2c_en | output | 1 | Enable for the I2C target, 0 in SPI mode |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_addr | output | 7 | Register write address |
| reg_wdata | output | 8 | Register write data |

## Verification
The frame vectors cover four cases:
- A single data byte at a fixed address.
- Three bytes with auto-increment, which shows that each byte reaches its own address.
- Three bytes without the flag, which must all land on one address.
- A pointer at 0x7E with the flag set, which exposes the wrap from 0x7F to 0x00.

Two frames carry a bad identity byte: 0x99, and 0x19. Because 0x19 is 0x98 with its bits reversed, that frame fails only on a design that shifts bits least significant first. Directed tests hold the shared pin low through reset to confirm that no falling edge is inferred, and cut a byte short with chip select to confirm it is dropped while the next frame still lines up correctly.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] FRAME_ID = 8'h98;

  typedef enum logic [1:0] {FR_ID, FR_PTR, FR_DATA, FR_DROP} frame_st_e;

  // Pointer after a data write: the low bits step when the top flag is set.
  function automatic logic [BYTE_W-1:0] ptr_after_write(input logic [BYTE_W-1:0] ptr);
    logic [ADDR_W-1:0] low;
    low = ptr[ADDR_W-1:0];
    if (ptr[BYTE_W-1]) low = low + 1'b1;
    return {ptr[BYTE_W-1], low};
  endfunction

  function automatic logic id_ok(input logic [BYTE_W-1:0] b);
    return b == FRAME_ID;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/spi_mode_latch.sv
module spi_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  output logic spi_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spi_mode <= 1'b0;
    else if (cs_fall) spi_mode <= 1'b1;
  end

  // R2: mode is sticky until reset
  p_mode_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val
);
  logic [BIT_CNT_W-1:0] cnt;
  logic [BYTE_W-2:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clear) begin
      cnt <= '0;
      sh  <= '0;
    end else if (bit_stb) begin
      cnt <= cnt + 1'b1;
      sh  <= {sh[BYTE_W-3:0], bit_val};
    end
  end

  assign byte_stb = bit_stb && !clear && (cnt == BIT_CNT_W'(BYTE_W - 1));
  assign byte_val = {sh, bit_val};

  // R9: closing the frame restarts bit counting
  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  // R4: bits are counted only on serial clock rising edges
  p_hold_between_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !clear) |=> $stable(cnt));
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  frame_st_e         st;
  logic [BYTE_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FR_ID;
      ptr      <= '0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= 1'b0;
      if (!frame_on) begin
        st <= FR_ID;
      end else if (byte_stb) begin
        case (st)
          FR_ID:  st <= id_ok(byte_val) ? FR_PTR : FR_DROP;
          FR_PTR: begin
            ptr <= byte_val;
            st  <= FR_DATA;
          end
          FR_DATA: begin
            wr_pulse <= 1'b1;
            wr_addr  <= ptr[ADDR_W-1:0];
            wr_data  <= byte_val;
            ptr      <= ptr_after_write(ptr);
          end
          default: ;
        endcase
      end
    end
  end

  // R9: writes only come from an open frame
  p_write_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(frame_on));
  // R7: each write strobe lasts one cycle
  p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  // R5: a rejected frame stays silent
  p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_DROP) |=> !wr_pulse);
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_cs_ad0,
  input  logic              pin_cclk,
  input  logic              pin_cdin,
  output logic              spi_mode,
  output logic              i2c_en,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata
);
  logic [2:0]        lvl;
  logic              cs_s, cclk_s, cdin_s;
  logic              cs_prev, cclk_prev;
  logic              cs_fall, cclk_rise, frame_on;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_in({pin_cs_ad0, pin_cclk, pin_cdin}),
    .lvl(lvl)
  );
  assign {cs_s, cclk_s, cdin_s} = lvl;

  // Previous levels reset low: a pin low at reset release is not a fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b0;
      cclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      cclk_prev <= cclk_s;
    end
  end

  assign cs_fall   = cs_prev && !cs_s;
  assign cclk_rise = cclk_s && !cclk_prev;
  assign frame_on  = spi_mode && !cs_s;

  spi_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .spi_mode(spi_mode)
  );

  spi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(!frame_on),
    .bit_stb(cclk_rise), .bit_val(cdin_s),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  spi_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on),
    .byte_stb(byte_stb), .byte_val(byte_val),
    .wr_pulse(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata)
  );

  assign i2c_en = !spi_mode;

  // R3: no register write before SPI mode is selected
  p_no_write_in_i2c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> spi_mode);
endmodule

// File: tb/tb_spi_ctl_port.sv
module tb_spi_ctl_port;
  typedef struct packed {
    logic [7:0] id;
    logic [7:0] map;
    logic [1:0] n;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [7:0] d2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'h98, 8'h05, 2'd1, 8'h3C, 8'h00, 8'h00},
    '{8'h98, 8'h8A, 2'd3, 8'hA5, 8'h5A, 8'h01},
    '{8'h98, 8'h12, 2'd3, 8'h11, 8'h22, 8'h33},
    '{8'h99, 8'h05, 2'd2, 8'hFF, 8'hEE, 8'h00},
    '{8'h98, 8'hFE, 2'd3, 8'hC1, 8'hC2, 8'hC3},
    '{8'h19, 8'h98, 2'd1, 8'h44, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic cs = 0, cclk = 0, cdin = 0;
  logic spi_mode, i2c_en, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  int checks = 0, fails = 0, wcnt = 0;
  logic [6:0] wa [8];
  logic [7:0] wd [8];
  bit done = 0;

  always #4 clk = ~clk;

  spi_ctl_port dut (
    .clk(clk), .rst_n(rst_n), .pin_cs_ad0(cs), .pin_cclk(cclk), .pin_cdin(cdin),
    .spi_mode(spi_mode), .i2c_en(i2c_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  always @(negedge clk) begin
    if (reg_we) begin
      if (wcnt < 8) begin
        wa[wcnt] = reg_addr;
        wd[wcnt] = reg_wdata;
      end
      wcnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      cdin = b[i];
      cclk = 0;
      wait_clk(4);
      cclk = 1;
      wait_clk(4);
    end
    cclk = 0;
  endtask

  task automatic open_frame();
    cs = 0;
    wait_clk(6);
  endtask

  task automatic close_frame();
    wait_clk(4);
    cs = 1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    // R1: reset state
    check("R1 spi_mode", spi_mode, 0);
    check("R1 i2c_en", i2c_en, 1);
    check("R1 reg_we", reg_we, 0);
    rst_n = 1;
    wait_clk(6);
    // R2: pin low since reset is no falling edge; R3 no write before SPI mode
    send_bits(8'h98, 8); send_bits(8'h01, 8); send_bits(8'h77, 8);
    wait_clk(8);
    check("R2 no fall at reset", spi_mode, 0);
    check("R3 no write in I2C mode", wcnt, 0);
    cs = 1;
    wait_clk(10);
    check("R2 rise does not select", spi_mode, 0);

    for (int v = 0; v < NV; v++) begin
      int en;
      logic [7:0] dv [3];
      dv[0] = VEC[v].d0; dv[1] = VEC[v].d1; dv[2] = VEC[v].d2;
      wcnt = 0;
      open_frame();
      send_bits(VEC[v].id, 8);
      send_bits(VEC[v].map, 8);
      for (int k = 0; k < int'(VEC[v].n); k++) send_bits(dv[k], 8);
      close_frame();
      en = (VEC[v].id == 8'h98) ? int'(VEC[v].n) : 0;
      // R5 wrong identity byte (0x19 catches LSB-first, R4) gives no writes; R7 one write per byte
      check($sformatf("R5/R7 write count vec %0d", v), wcnt, en);
      for (int k = 0; k < en; k++) begin
        int ea;
        ea = (VEC[v].map % 128 + (VEC[v].map >= 128 ? k : 0)) % 128;
        // R6 pointer address, R8 increment and wrap
        check($sformatf("R6/R8 addr vec %0d byte %0d", v, k), wa[k], ea);
        check($sformatf("R4/R7 data vec %0d byte %0d", v, k), wd[k], dv[k]);
      end
      if (v == 0) begin
        check("R2 fall selects SPI", spi_mode, 1);
        check("R3 i2c disabled", i2c_en, 0);
      end
    end

    // R9: partial byte dropped at chip select rise
    wcnt = 0;
    open_frame();
    send_bits(8'h98, 8); send_bits(8'h20, 8); send_bits(8'hF0, 5);
    close_frame();
    check("R9 partial byte dropped", wcnt, 0);
    // R9: bit counter restarted, next frame aligned
    open_frame();
    send_bits(8'h98, 8); send_bits(8'h21, 8); send_bits(8'h6B, 8);
    close_frame();
    check("R9 next frame write count", wcnt, 1);
    check("R9 next frame addr", wa[0], 8'h21);
    check("R9 next frame data", wd[0], 8'h6B);
    check("R2 mode sticky", spi_mode, 1);

    // R1/R2: reset clears mode
    rst_n = 0;
    wait_clk(2);
    check("R1 reset clears mode", spi_mode, 0);
    check("R1 reset enables I2C", i2c_en, 1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule